// File: doc/BRIEF.md
# DDR2 Read Sequencer

This block sits between a host and the user port of a DDR2 memory controller and performs one 128-bit read at a time. When the host raises its read request, the block checks that the memory is ready: initialisation must be finished, refresh must be done and no other command may be in flight. If all three hold, it latches the address and raises the read command. It keeps the command up until the controller acknowledges it. It then waits two fixed cycles and pulses burst-done for two cycles.

The controller returns the data as two 64-bit beats, each marked by a valid strobe. A separate data process places the first beat in the low half of a 128-bit buffer and the second beat in the high half, then raises a buffer-full flag. The command process parks in an end state. It goes back to idle only after the host has dropped its request and the data process has finished with a full buffer, so a new read cannot overwrite data that has not yet been taken.

An activity flag stays high from the moment a read is issued until the block is idle again. The write path is expected to include this flag in its own busy test.

Top module: `ddr2_rd_seq`

## Requirements
- R1: While reset is asserted and right after it, `ctl_rd_cmd`, `ctl_burst_done`, `buf_full` and `rd_active` are 0, and `ctl_addr` and `rd_buf` are all zeros.
- R2: From idle, a read is issued at the next clock edge only if `host_rd_req`, `mem_init_done` and `mem_refresh_done` are all 1 and `cmd_busy` is 0 at that edge. Otherwise the block stays idle.
- R3: `ctl_rd_cmd` rises on the edge that issues the read and stays 1 until the first edge where `ctl_rd_ack` is 1. `ctl_addr` takes `host_addr` on the issuing edge and holds that value until the next issue.
- R4: After the acknowledging edge, two wait cycles follow with `ctl_burst_done` at 0. `ctl_burst_done` is then 1 for exactly two consecutive cycles.
- R5: During an active read, the first beat with `ctl_rd_valid` at 1 is stored in `rd_buf[63:0]`. The next beat with valid at 1 is stored in `rd_buf[127:64]`.
- R6: `buf_full` becomes 1 on the edge that stores the high half. It returns to 0 on the edge that issues the next read.
- R7: After burst-done, the block leaves its end state only on an edge where `host_rd_req` is 0, `buf_full` is 1 and the data process is idle again because valid has dropped after the high beat.
- R8: Beats presented while `rd_active` is 0 leave `rd_buf` unchanged.
- R9: `rd_active` is 1 from the issuing edge until the edge that returns the command process to idle.
- R10: Further valid beats after the high half has been stored are ignored until valid drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd_req | input | 1 | Host read request, level |
| host_addr | input | ADDR_W | Host read address |
| mem_init_done | input | 1 | Memory initialisation finished |
| mem_refresh_done | input | 1 | Refresh finished, commands allowed |
| cmd_busy | input | 1 | Another command (write) is active |
| ctl_rd_ack | input | 1 | Controller accepted the read command |
| ctl_rd_valid | input | 1 | Read beat valid |
| ctl_rd_data | input | BEAT_W | Read beat data |
| ctl_rd_cmd | output | 1 | Read command to controller |
| ctl_addr | output | ADDR_W | Latched read address |
| ctl_burst_done | output | 1 | Burst-done, two-cycle pulse |
| rd_buf | output | 2*BEAT_W | Reassembled read buffer |
| buf_full | output | 1 | Both halves of the buffer written |
| rd_active | output | 1 | A read is in progress |

## Verification
Several rules are checked by assertions on every cycle:
- the read command is held until the acknowledge arrives;
- the command only rises when its gating conditions were true;
- the burst-done pulse is exactly two cycles long;
- the full flag is clear when a command starts;
- the command never appears while the activity flag is low;
- the activity flag only falls after the request has dropped with a full buffer.

Other behaviours only the bench scenarios can show, by comparing with a reference model every cycle:
- which beat lands in which half of the buffer;
- that stray or extra beats are dropped;
- that the two wait cycles are placed correctly;
- that the end state holds while the host keeps its request up or the data has not arrived.

// File: rtl/ddr2_rd_seq.sv
module ddr2_rd_seq #(
  parameter int ADDR_W = 27,
  parameter int BEAT_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_rd_req,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                mem_init_done,
  input  logic                mem_refresh_done,
  input  logic                cmd_busy,
  input  logic                ctl_rd_ack,
  input  logic                ctl_rd_valid,
  input  logic [BEAT_W-1:0]   ctl_rd_data,
  output logic                ctl_rd_cmd,
  output logic [ADDR_W-1:0]   ctl_addr,
  output logic                ctl_burst_done,
  output logic [2*BEAT_W-1:0] rd_buf,
  output logic                buf_full,
  output logic                rd_active
);

  localparam int BUF_W = 2 * BEAT_W;

  typedef enum logic [2:0] {
    C_IDLE, C_ISSUE, C_WAIT1, C_WAIT2, C_BD1, C_BD2, C_END
  } cmd_st_t;

  typedef enum logic [1:0] {D_IDLE, D_LO, D_HI} dat_st_t;

  cmd_st_t cst;
  dat_st_t dst;

  logic can_issue, issue, release_ok;

  assign can_issue  = host_rd_req && mem_init_done && mem_refresh_done && !cmd_busy;
  assign issue      = (cst == C_IDLE) && can_issue;
  assign release_ok = !host_rd_req && buf_full && (dst == D_IDLE);

  assign ctl_rd_cmd     = (cst == C_ISSUE);
  assign ctl_burst_done = (cst == C_BD1) || (cst == C_BD2);
  assign rd_active      = (cst != C_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst      <= C_IDLE;
      ctl_addr <= '0;
    end else begin
      case (cst)
        C_IDLE:  if (issue) begin
                   cst      <= C_ISSUE;
                   ctl_addr <= host_addr;
                 end
        C_ISSUE: if (ctl_rd_ack) cst <= C_WAIT1;
        C_WAIT1: cst <= C_WAIT2;
        C_WAIT2: cst <= C_BD1;
        C_BD1:   cst <= C_BD2;
        C_BD2:   cst <= C_END;
        C_END:   if (release_ok) cst <= C_IDLE;
        default: cst <= C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst      <= D_IDLE;
      rd_buf   <= '0;
      buf_full <= 1'b0;
    end else begin
      case (dst)
        D_IDLE: if (rd_active && ctl_rd_valid) begin
                  rd_buf[BEAT_W-1:0] <= ctl_rd_data;
                  dst <= D_LO;
                end
        D_LO:   if (ctl_rd_valid) begin
                  rd_buf[BUF_W-1:BEAT_W] <= ctl_rd_data;
                  dst <= D_HI;
                end
        D_HI:   if (!ctl_rd_valid) dst <= D_IDLE;
        default: dst <= D_IDLE;
      endcase
      if (issue)
        buf_full <= 1'b0;
      else if (dst == D_LO && ctl_rd_valid)
        buf_full <= 1'b1;
    end
  end

  // R2
  issue_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rd_cmd) |-> $past(can_issue));

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_cmd && !ctl_rd_ack) |=> ctl_rd_cmd);

  // R4
  burst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_burst_done) |=> ctl_burst_done);

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_burst_done && $past(ctl_burst_done)) |=> !ctl_burst_done);

  // R6
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rd_cmd) |-> !buf_full);

  // R9
  active_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_cmd |-> rd_active);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_active) |-> $past(!host_rd_req && buf_full));

endmodule

// File: tb/ddr2_rd_seq_bench.sv
`timescale 1ns/1ps
module ddr2_rd_seq_bench;
  localparam int AW = 27;
  localparam int BW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, init = 0, refr = 0, busy = 0, ack = 0, vld = 0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] data = '0;
  logic cmd, bd, full, act;
  logic [AW-1:0] caddr;
  logic [2*BW-1:0] buff;

  always #2.5 clk = ~clk;

  ddr2_rd_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_ddr2_rd_seq (
    .clk(clk), .rst_n(rst_n), .host_rd_req(req), .host_addr(addr),
    .mem_init_done(init), .mem_refresh_done(refr), .cmd_busy(busy),
    .ctl_rd_ack(ack), .ctl_rd_valid(vld), .ctl_rd_data(data),
    .ctl_rd_cmd(cmd), .ctl_addr(caddr), .ctl_burst_done(bd),
    .rd_buf(buff), .buf_full(full), .rd_active(act));

  // reference model: phase 0 idle, 1 issued, 2-3 wait, 4-5 burst-done, 6 end
  int ph = 0, dph = 0;
  logic [2*BW-1:0] mbuf = '0;
  logic mfull = 0;
  logic [AW-1:0] maddr = '0;
  int compared = 0, mism = 0;
  bit done = 0;

  always @(posedge clk) begin
    int p0, d0;
    logic f0;
    p0 = ph; d0 = dph; f0 = mfull;
    if (!rst_n) begin
      ph = 0; dph = 0; mbuf = '0; mfull = 0; maddr = '0;
    end else begin
      if (d0 == 0 && p0 != 0 && vld) begin mbuf[BW-1:0] = data; dph = 1; end
      else if (d0 == 1 && vld) begin mbuf[2*BW-1:BW] = data; dph = 2; mfull = 1; end
      else if (d0 == 2 && !vld) dph = 0;
      if (p0 == 0) begin
        if (req && init && refr && !busy) begin ph = 1; maddr = addr; mfull = 0; end
      end else if (p0 == 1) begin
        if (ack) ph = 2;
      end else if (p0 < 6) ph = p0 + 1;
      else if (!req && f0 && d0 == 0) ph = 0;
    end
  end

  task automatic cmp(string tag, logic [2*BW-1:0] got, logic [2*BW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mism++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("R3 cmd", 128'(cmd), 128'(ph == 1));
    cmp("R3 addr", 128'(caddr), 128'(maddr));
    cmp("R4 burst_done", 128'(bd), 128'(ph == 4 || ph == 5));
    cmp("R5 buffer", buff, mbuf);
    cmp("R6 full", 128'(full), 128'(mfull));
    cmp("R9 active", 128'(act), 128'(ph != 0));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beats(logic [BW-1:0] lo, logic [BW-1:0] hi, int extra);
    vld = 1; data = lo; tick(1);
    data = hi; tick(1);
    for (int i = 0; i < extra; i++) begin data = ~hi; tick(1); end
    vld = 0; data = '0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000 && !done) begin
      done = 1; mism++; compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end

  initial begin
    tick(3);
    cmp("R1 reset cmd", 128'(cmd), 0);
    cmp("R1 reset buf", buff, 0);
    rst_n = 1; tick(1);
    // R8: stray beat while idle
    vld = 1; data = 64'hDEAD_BEEF_0000_0001; tick(2); vld = 0; tick(1);
    cmp("R8 stray ignored", buff, 0);
    // R2: gating
    req = 1; addr = 27'h123_4567; tick(3);
    cmp("R2 no init", 128'(act), 0);
    init = 1; tick(3);
    cmp("R2 no refresh", 128'(act), 0);
    refr = 1; busy = 1; tick(3);
    cmp("R2 busy", 128'(act), 0);
    busy = 0; tick(1);
    cmp("R2 issued", 128'(cmd), 1);
    tick(2);
    ack = 1; tick(1); ack = 0;
    tick(1);
    // R10: one extra beat after the high half
    beats(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1);
    tick(5);
    cmp("R7 held while req high", 128'(act), 1);
    req = 0; tick(2);
    cmp("R7 released", 128'(act), 0);
    cmp("R10 extra ignored", buff, {64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444});
    // second read: request drops before data arrives
    req = 1; addr = 27'h0AB_CDEF; tick(1); req = 0;
    cmp("R6 full cleared", 128'(full), 0);
    ack = 1; tick(1); ack = 0;
    tick(8);
    cmp("R7 waits for data", 128'(act), 1);
    beats(64'hAAAA_0000_BBBB_1111, 64'hCCCC_2222_DDDD_3333, 0);
    tick(3);
    cmp("R7 released after data", 128'(act), 0);
    // R8 again while idle with a full buffer
    vld = 1; data = '1; tick(1); vld = 0; tick(1);
    cmp("R8 idle beat", buff, {64'hCCCC_2222_DDDD_3333, 64'hAAAA_0000_BBBB_1111});
    // third read with delayed ack and gap between beats
    req = 1; addr = '1; tick(1);
    tick(4); ack = 1; tick(1); ack = 0; tick(3);
    vld = 1; data = 64'h0F0F; tick(1); vld = 0; tick(2);
    vld = 1; data = 64'hF0F0; tick(1); vld = 0;
    req = 0; tick(6);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule